// File: doc/BRIEF.md
# Masked General-Purpose I/O Port Controller

This block is one 32-pin general-purpose I/O port with a small memory-mapped register set. Software chooses per pin whether it drives or listens (direction register), drives values through an output latch, and reads the pad state through a two-flop synchronizer. The latch can be loaded in three ways: a full pin-value write, a set write where 1 bits turn latch bits on, and a clear write where 1 bits turn them off.

A per-pin mask register protects pins from all three kinds of latch write. It also hides those pins on a pin-value read, where they return 0. So one piece of software can own a subset of pins without read-modify-write races. Every register accepts word, half-word and byte writes through four byte-lane strobes.

The bus address is a byte address. Bits [4:2] pick the register word and the strobes pick the lanes, so the upper half-word at offset 2 is reached with strobes 4'b1100. Reads always return the full word, one cycle after the request.

Top module: `gpio_mask_port`

## Requirements
- R1: While reset is held and right after it, the direction, mask and output latch are all zero: `pin_oe`, `pin_out` and `bus_rdata` are 0, and the direction and mask read back as 0.
- R2: The direction register is at word offset 0x00. `pin_oe[n]` equals direction bit n (1 = output, 0 = input), and the register reads back as written.
- R3: The mask register is at word offset 0x10 and reads back as written.
- R4: A write to the pin-value register (offset 0x14) loads output-latch bit n from write-data bit n, only where the lane is strobed and mask bit n is 0. All other latch bits keep their value. `pin_out` shows the result right after the capturing clock edge.
- R5: A write to the set register (offset 0x18) turns on latch bits that have data 1, an unmasked bit and a strobed lane. A write to the clear register (offset 0x1C) turns those bits off in the same way. Data 0 bits and masked bits are left unchanged.
- R6: A read of the pin-value register returns the synchronized pad input for unmasked bits and 0 for masked bits.
- R7: Strobe bit k covers data bits [8k+7:8k], which are pins 8k to 8k+7. A lane whose strobe is 0 keeps its bits unchanged in every register: direction, mask, and the latch through pin-value, set and clear writes.
- R8: A pad input change made before rising edge E0 is not seen by reads captured at E0 or E0+1. It is seen by a read captured at E0+2.
- R9: `bus_rdata` holds the read result for the cycle after the request edge and is 0 in any cycle after an edge with no read. Set, clear and the unused offsets 0x04, 0x08 and 0x0C read as 0, and writes to the unused offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 5 | Byte address; bits [4:2] select the register word |
| bus_wr | input | 1 | Write request, captured on the rising edge |
| bus_be | input | 4 | Byte-lane write strobes |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read request |
| bus_rdata | output | 32 | Read data, registered |
| pin_in | input | 32 | Pad input levels (asynchronous) |
| pin_out | output | 32 | Output latch value |
| pin_oe | output | 32 | Output enables (1 = drive) |

## Verification
The hardest case to reach is a latch write that lands on a mixture of masked bits, unstrobed lanes and zero data bits, because the bit that should change is hidden among bits that must not. The bench reaches it by sweeping all sixteen strobe patterns for each of the pin-value, set and clear writes. Before each write it loads a fresh pseudo-random mask and uses fresh data, and it compares `pin_out` against a bench model after every write. The synchronizer edge is pinned down by changing the pads together with a read held high across three edges, so the reads that see the old value and the one that sees the new value are each checked.

// File: rtl/gmp_pkg.sv
// Package: register word indices shared by the port controller and its parts.
// Assumes a 32-bit bus, so a register word is selected by byte-address bits [4:2].
package gmp_pkg;
    localparam int WORD_DIR  = 0;   // direction, byte offset 0x00
    localparam int WORD_MASK = 4;   // mask, byte offset 0x10
    localparam int WORD_PIN  = 5;   // pin value, byte offset 0x14
    localparam int WORD_SET  = 6;   // set, byte offset 0x18
    localparam int WORD_CLR  = 7;   // clear, byte offset 0x1C
    localparam int LANE_W    = 8;   // bits per byte lane
endpackage

// File: rtl/gmp_lane_reg.sv
// Module: byte-lane strobed register (used for direction and mask).
// Assumes WIDTH is a multiple of 8; lanes that are not strobed hold their value.
module gmp_lane_reg #(
    parameter int WIDTH = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [WIDTH/8-1:0]      be,
    input  logic [WIDTH-1:0]        wdata,
    output logic [WIDTH-1:0]        q
);
    import gmp_pkg::*;
    localparam int LANES = WIDTH / LANE_W;

    logic [WIDTH-1:0] lane_bits;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        // Update one lane when written with its strobe set
        always_ff @(posedge clk) begin
            if (!rst_n)
                q[l*LANE_W +: LANE_W] <= '0;
            else if (wr_en && be[l])
                q[l*LANE_W +: LANE_W] <= wdata[l*LANE_W +: LANE_W];
        end
        assign lane_bits[l*LANE_W +: LANE_W] = {LANE_W{wr_en & be[l]}};
    end

    // R7: bits outside the strobed lanes never change
    p_lane_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((q ^ $past(q)) & ~$past(lane_bits)) == '0);
endmodule

// File: rtl/gmp_out_latch.sv
// Module: output latch with load, set and clear writes gated by lane and mask.
// Assumes at most one of ld_en/set_en/clr_en is high (they decode one address).
module gmp_out_latch #(
    parameter int WIDTH = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_en,
    input  logic              set_en,
    input  logic              clr_en,
    input  logic [WIDTH-1:0]  lane_bits,
    input  logic [WIDTH-1:0]  mask,
    input  logic [WIDTH-1:0]  wdata,
    output logic [WIDTH-1:0]  q
);
    logic [WIDTH-1:0] en;

    // Bits that a write may touch: strobed and not masked
    assign en = lane_bits & ~mask;

    // Apply the selected kind of latch write
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (ld_en)
            q <= (q & ~en) | (wdata & en);
        else if (set_en)
            q <= q | (wdata & en);
        else if (clr_en)
            q <= q & ~(wdata & en);
    end

    // R4: masked bits never change
    p_mask_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((q ^ $past(q)) & $past(mask)) == '0);
    // R5: a set write never turns a bit off
    p_set_no_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |=> ($past(q) & ~q) == '0);
    // R5: a clear write never turns a bit on
    p_clr_no_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |=> (~$past(q) & q) == '0);
    // R9: without a latch write the latch holds
    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(ld_en || set_en || clr_en) |=> $stable(q));
endmodule

// File: rtl/gmp_in_sync.sv
// Module: two-flop synchronizer for the pad inputs.
// Assumes each pin is an independent level; no multi-bit coherence is implied.
module gmp_in_sync #(
    parameter int WIDTH = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WIDTH-1:0]  d,
    output logic [WIDTH-1:0]  q
);
    logic [WIDTH-1:0] stage1;

    // Two-stage capture of the asynchronous pad levels
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end

    // R8: output is the pad level from exactly two edges earlier
    p_sync_age_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ##1 (q == $past(d, 2)));
endmodule

// File: rtl/gpio_mask_port.sv
// Module: masked 32-pin GPIO port, top level.
// Decodes word address and byte strobes, holds the direction and mask registers,
// the output latch and the input synchronizer, and registers the read data.
// Assumes bus_wr and bus_rd are single-cycle qualified requests on a byte address.
module gpio_mask_port #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_wr,
    input  logic [DATA_W/8-1:0] bus_be,
    input  logic [DATA_W-1:0]  bus_wdata,
    input  logic               bus_rd,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic [DATA_W-1:0]  pin_in,
    output logic [DATA_W-1:0]  pin_out,
    output logic [DATA_W-1:0]  pin_oe
);
    import gmp_pkg::*;
    localparam int LANES = DATA_W / LANE_W;
    localparam int LSB   = $clog2(LANES);
    localparam int SEL_W = ADDR_W - LSB;

    logic [SEL_W-1:0]  sel;
    logic [DATA_W-1:0] lane_bits;
    logic [DATA_W-1:0] dir_q;
    logic [DATA_W-1:0] mask_q;
    logic [DATA_W-1:0] sync_q;
    logic              wr_dir, wr_mask, wr_pin, wr_set, wr_clr;

    assign sel = bus_addr[ADDR_W-1:LSB];

    for (genvar l = 0; l < LANES; l++) begin : g_lanes
        assign lane_bits[l*LANE_W +: LANE_W] = {LANE_W{bus_be[l]}};
    end

    // Write decode per register word
    assign wr_dir  = bus_wr && (int'(sel) == WORD_DIR);
    assign wr_mask = bus_wr && (int'(sel) == WORD_MASK);
    assign wr_pin  = bus_wr && (int'(sel) == WORD_PIN);
    assign wr_set  = bus_wr && (int'(sel) == WORD_SET);
    assign wr_clr  = bus_wr && (int'(sel) == WORD_CLR);

    gmp_lane_reg #(.WIDTH(DATA_W)) u_dir (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_dir), .be(bus_be),
        .wdata(bus_wdata), .q(dir_q));

    gmp_lane_reg #(.WIDTH(DATA_W)) u_mask (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_mask), .be(bus_be),
        .wdata(bus_wdata), .q(mask_q));

    gmp_out_latch #(.WIDTH(DATA_W)) u_latch (
        .clk(clk), .rst_n(rst_n), .ld_en(wr_pin), .set_en(wr_set),
        .clr_en(wr_clr), .lane_bits(lane_bits), .mask(mask_q),
        .wdata(bus_wdata), .q(pin_out));

    gmp_in_sync #(.WIDTH(DATA_W)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pin_in), .q(sync_q));

    assign pin_oe = dir_q;

    // Registered read mux; zero when no read is requested
    always_ff @(posedge clk) begin
        if (!rst_n)
            bus_rdata <= '0;
        else if (bus_rd) begin
            case (int'(sel))
                WORD_DIR:  bus_rdata <= dir_q;
                WORD_MASK: bus_rdata <= mask_q;
                WORD_PIN:  bus_rdata <= sync_q & ~mask_q;
                default:   bus_rdata <= '0;
            endcase
        end else
            bus_rdata <= '0;
    end

    // R6: masked bits of a pin-value read return 0
    p_rd_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && int'(sel) == WORD_PIN) |=> (bus_rdata & $past(mask_q)) == '0);
    // R9: no read request leaves read data at zero
    p_idle_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> bus_rdata == '0);
    // R2: direction changes only on a direction write
    p_dir_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_dir |=> $stable(pin_oe));
endmodule

// File: tb/gpio_mask_port_test.sv
// Bench: sweeps strobe patterns, masks and data against an arithmetic model.
module gpio_mask_port_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out;
    logic [31:0] pin_oe;

    int checks = 0;
    int fails  = 0;
    logic [31:0] seed = 32'h1234_5678;
    logic [31:0] dir_m = '0, mask_m = '0, lat_m = '0;

    gpio_mask_port uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rd(bus_rd),
        .bus_rdata(bus_rdata), .pin_in(pin_in), .pin_out(pin_out),
        .pin_oe(pin_oe));

    always #10 clk = ~clk;

    function automatic logic [31:0] lanes(input logic [3:0] be);
        return {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
    endfunction

    task automatic rnd(output logic [31:0] v);
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 17);
        seed = seed ^ (seed << 5);
        v = seed;
    endtask

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic do_write(input logic [4:0] a, input logic [31:0] d,
                            input logic [3:0] be);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_be = be; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic do_read(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    // Watchdog: a hung run ends as a failure
    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] d, r, lm, en, a_val, b_val;
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1", pin_oe, 32'h0, "pin_oe in reset");
        check("R1", pin_out, 32'h0, "pin_out in reset");
        check("R1", bus_rdata, 32'h0, "rdata in reset");
        rst_n = 1'b1;
        do_read(5'h00, r); check("R1", r, 32'h0, "dir after reset");
        do_read(5'h10, r); check("R1", r, 32'h0, "mask after reset");
        check("R1", pin_out, 32'h0, "pin_out after reset");

        // R2/R7: direction register over every strobe pattern
        for (int be = 0; be < 16; be++) begin
            rnd(d);
            lm = lanes(4'(be));
            do_write((be == 12) ? 5'h02 : 5'h00, d, 4'(be));
            dir_m = (dir_m & ~lm) | (d & lm);
            check("R2", pin_oe, dir_m, "pin_oe after dir write");
            do_read(5'h00, r); check("R7", r, dir_m, "dir lanes readback");
        end

        // R3/R7: mask register over every strobe pattern
        for (int be = 0; be < 16; be++) begin
            rnd(d);
            lm = lanes(4'(be));
            do_write(5'h10, d, 4'(be));
            mask_m = (mask_m & ~lm) | (d & lm);
            do_read(5'h10, r); check("R3", r, mask_m, "mask lanes readback");
        end

        // R4/R5/R7: latch writes under random mask and every strobe pattern
        for (int op = 0; op < 3; op++) begin
            for (int be = 0; be < 16; be++) begin
                for (int k = 0; k < 2; k++) begin
                    rnd(mask_m);
                    do_write(5'h10, mask_m, 4'hF);
                    rnd(d);
                    en = lanes(4'(be)) & ~mask_m;
                    if (op == 0) begin
                        do_write(5'h14, d, 4'(be));
                        lat_m = (lat_m & ~en) | (d & en);
                        check("R4", pin_out, lat_m, "pin-value write");
                    end else if (op == 1) begin
                        do_write(5'h18, d, 4'(be));
                        lat_m = lat_m | (d & en);
                        check("R5", pin_out, lat_m, "set write");
                    end else begin
                        do_write(5'h1C, d, 4'(be));
                        lat_m = lat_m & ~(d & en);
                        check("R5", pin_out, lat_m, "clear write");
                    end
                end
            end
        end
        // R5: zero data has no effect on set or clear
        mask_m = '0; do_write(5'h10, 32'h0, 4'hF);
        do_write(5'h18, 32'h0, 4'hF); check("R5", pin_out, lat_m, "set zero data");
        do_write(5'h1C, 32'h0, 4'hF); check("R5", pin_out, lat_m, "clear zero data");

        // R6: pin-value read under various masks
        for (int i = 0; i < 26; i++) begin
            if (i == 0) mask_m = 32'hFFFF_FFFF;
            else if (i == 1) mask_m = 32'h0;
            else rnd(mask_m);
            do_write(5'h10, mask_m, 4'hF);
            rnd(d);
            @(negedge clk); pin_in = d;
            repeat (3) @(negedge clk);
            do_read(5'h14, r);
            check("R6", r, d & ~mask_m, "pin-value read");
        end

        // R8: synchronizer latency seen from a held read
        mask_m = '0; do_write(5'h10, 32'h0, 4'hF);
        a_val = 32'hA5A5_0F0F; b_val = 32'h5A5A_F0F0;
        @(negedge clk); pin_in = a_val;
        repeat (4) @(negedge clk);
        bus_addr = 5'h14; bus_rd = 1'b1; pin_in = b_val;
        @(negedge clk); check("R8", bus_rdata, a_val, "read at first edge");
        @(negedge clk); check("R8", bus_rdata, a_val, "read at second edge");
        @(negedge clk); check("R8", bus_rdata, b_val, "read at third edge");
        bus_rd = 1'b0;

        // R9: idle zero, unmapped and write-only offsets
        @(negedge clk); check("R9", bus_rdata, 32'h0, "idle rdata");
        do_read(5'h04, r); check("R9", r, 32'h0, "read 0x04");
        do_read(5'h08, r); check("R9", r, 32'h0, "read 0x08");
        do_read(5'h0C, r); check("R9", r, 32'h0, "read 0x0C");
        do_read(5'h18, r); check("R9", r, 32'h0, "read set");
        do_read(5'h1C, r); check("R9", r, 32'h0, "read clear");
        do_write(5'h04, 32'hFFFF_FFFF, 4'hF);
        do_write(5'h0C, 32'hFFFF_FFFF, 4'hF);
        check("R9", pin_out, lat_m, "pin_out after unmapped write");
        check("R9", pin_oe, dir_m, "pin_oe after unmapped write");
        do_read(5'h10, r); check("R9", r, 32'h0, "mask after unmapped write");

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule